// File: doc/BRIEF.md
# Posted Write Buffer Controller

This block sits between a processor bus and a slower memory port. A processor write is finished on the bus as soon as its address and data are captured into a small first-in first-out queue. The processor gets its ready acknowledge at once, and the store to memory happens later, one entry at a time. When the queue is full, the block lowers a write-permission output (`wr_open`). The processor then stops issuing writes, but reads stay free to use the bus. Writes are never throttled by holding back the ready acknowledge, because that would stall every kind of bus request.

A read goes to the memory port through the same single-transfer sequencer. When the port is free, a read whose address matches no queued write is sent ahead of the queued writes. A read that matches a queued write waits until that entry has been written to memory, so a read always sees the data written before it.

Both sides use a hold-until-acknowledged protocol. The processor keeps `cpu_req` and its fields steady until it sees `cpu_ready`. The block keeps `mem_req` and its fields steady until it sees `mem_ack`.

Top module: `pwb_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `wr_open` is 1, `cpu_ready` is 0 and `mem_req` is 0, with the queue empty.
- R2: A write (`cpu_write`=1) presented while `wr_open` is 1 gets `cpu_ready` in the next cycle, whatever the memory is doing. Every `cpu_ready` is a one-cycle pulse that follows a cycle in which `cpu_req` was 1.
- R3: `wr_open` is 0 in the same cycle as the `cpu_ready` of the write that brings the queue to DEPTH entries (default 2). It stays 1 at the `cpu_ready` of a write that leaves a free slot.
- R4: A write presented while `wr_open` is 0 gets no `cpu_ready` while the queue stays full. Its `cpu_ready` comes two cycles after the cycle in which `mem_ack` completes the drain that frees a slot.
- R5: `wr_open` is 1 in the cycle after every cycle in which `mem_ack` completes a write drain.
- R6: Queued writes reach the memory port with `mem_we`=1, in the order they were acknowledged, each with the address and data captured when it was posted.
- R7: A read is never refused because `wr_open` is 0. When the port is free and the read's address matches no queued entry, the read is issued before the writes still in the queue.
- R8: A read whose address matches a queued write is not issued until that write has been drained, and it returns the newly written data.
- R9: At most one memory transfer is outstanding. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay steady until `mem_ack`, and `mem_req` is 0 in the cycle after an acknowledge.
- R10: A read's `cpu_ready` comes in the cycle after its `mem_ack`, with `cpu_rdata` equal to the `mem_rdata` presented with that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_req | input | 1 | Processor cycle request, held until `cpu_ready` |
| cpu_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cpu_addr | input | AW | Processor cycle address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ready | output | 1 | One-cycle completion acknowledge |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` of a read |
| wr_open | output | 1 | 1 = the processor may issue a write |
| mem_req | output | 1 | Memory transfer request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | AW | Memory transfer address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle memory acknowledge |

## Verification
Writes are posted while the memory model is running, and then while it withholds write acknowledges. The first case shows that posting does not wait on memory. The second fills the queue and leaves a third write stalled, so the bench can time both the fall of `wr_open` and its return. Reads are placed behind a full queue in two ways: one to an address that is not queued and one to an address that is. The two cases separate the non-matching read, which overtakes the remaining queued write, from the matching read, which must wait for its entry. A final pattern of write-then-read-back and reads of untouched addresses checks that read data is always current.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  // State of the single-transfer memory sequencer.
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_WRITE = 2'd1,
    PORT_READ  = 2'd2
  } port_state_e;

endpackage

// File: rtl/pwb_queue.sv
// Posted-write FIFO with a per-entry address comparator for read ordering.
module pwb_queue #(
  parameter int DEPTH = 2,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] probe_addr,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  output logic          full_next,
  output logic          probe_hit
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAPACITY  = CW'(DEPTH);

  logic [PW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] hit_vec;
  logic [AW-1:0]    addr_mem [DEPTH];
  logic [DW-1:0]    data_mem [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  // Next-state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    vld_d    = vld_q;
    if (push) begin
      wr_ptr_d        = bump(wr_ptr_q);
      vld_d[wr_ptr_q] = 1'b1;
    end
    if (pop) begin
      rd_ptr_d        = bump(rd_ptr_q);
      vld_d[rd_ptr_q] = 1'b0;
    end
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      vld_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      vld_q    <= vld_d;
    end
  end

  // Storage: one enabled register pair and one comparator per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_ptr_q == PW'(g));

    always_ff @(posedge clk) begin
      if (slot_en) begin
        addr_mem[g] <= push_addr;
        data_mem[g] <= push_data;
      end
    end

    assign hit_vec[g] = vld_q[g] && (addr_mem[g] == probe_addr);
  end

  assign head_addr = addr_mem[rd_ptr_q];
  assign head_data = data_mem[rd_ptr_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CAPACITY);
  assign full_next = (cnt_d == CAPACITY);
  assign probe_hit = |hit_vec;

endmodule

// File: rtl/pwb_port.sv
// Memory-side sequencer: one transfer at a time, reads take priority at launch.
module pwb_port
  import pwb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_go,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          wr_done,
  output logic          rd_done
);

  port_state_e   state_q, state_d;
  logic          launch;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign launch = (state_q == PORT_IDLE) && (rd_go || wr_go);

  // Next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PORT_IDLE: begin
        if (rd_go)      state_d = PORT_READ;
        else if (wr_go) state_d = PORT_WRITE;
      end
      PORT_WRITE, PORT_READ: begin
        if (mem_ack) state_d = PORT_IDLE;
      end
      default: state_d = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PORT_IDLE;
    else        state_q <= state_d;
  end

  // Transfer fields, loaded only at launch
  always_ff @(posedge clk) begin
    if (launch) begin
      addr_q <= rd_go ? rd_addr : wr_addr;
      data_q <= wr_data;
    end
  end

  assign mem_req   = (state_q != PORT_IDLE);
  assign mem_we    = (state_q == PORT_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign wr_done   = (state_q == PORT_WRITE) && mem_ack;
  assign rd_done   = (state_q == PORT_READ) && mem_ack;

endmodule

// File: rtl/pwb_host.sv
// Processor-side acceptance, acknowledge pulse and write-permission flag.
module pwb_host #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_write,
  input  logic          q_full,
  input  logic          q_full_next,
  input  logic          rd_hit,
  input  logic          rd_done,
  input  logic [DW-1:0] mem_rdata,
  output logic          push,
  output logic          rd_go,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          wr_open
);

  logic          ready_q, ready_d;
  logic          open_q, open_d;
  logic          fresh;
  logic [DW-1:0] rdata_q;

  // A held request is new only while its acknowledge is not on the bus.
  assign fresh  = cpu_req && !ready_q;
  assign push   = fresh && cpu_write && !q_full;
  assign rd_go  = fresh && !cpu_write && !rd_hit;

  // Next-state
  always_comb begin
    ready_d = push || rd_done;
    open_d  = !q_full_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      open_q  <= 1'b1;
    end else begin
      ready_q <= ready_d;
      open_q  <= open_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_done) rdata_q <= mem_rdata;
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;
  assign wr_open   = open_q;

endmodule

// File: rtl/pwb_ctrl.sv
// Posted write buffer controller: top level.
module pwb_ctrl #(
  parameter int DEPTH = 2,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_write,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          wr_open,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);

  logic          push, pop;
  logic          q_empty, q_full, q_full_next, rd_hit;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic          rd_go, rd_done;

  pwb_queue #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_addr  (cpu_addr),
    .push_data  (cpu_wdata),
    .pop        (pop),
    .probe_addr (cpu_addr),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .empty      (q_empty),
    .full       (q_full),
    .full_next  (q_full_next),
    .probe_hit  (rd_hit)
  );

  pwb_host #(
    .DW(DW)
  ) u_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_write   (cpu_write),
    .q_full      (q_full),
    .q_full_next (q_full_next),
    .rd_hit      (rd_hit),
    .rd_done     (rd_done),
    .mem_rdata   (mem_rdata),
    .push        (push),
    .rd_go       (rd_go),
    .cpu_ready   (cpu_ready),
    .cpu_rdata   (cpu_rdata),
    .wr_open     (wr_open)
  );

  pwb_port #(
    .AW(AW), .DW(DW)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_go     (rd_go),
    .rd_addr   (cpu_addr),
    .wr_go     (!q_empty),
    .wr_addr   (head_addr),
    .wr_data   (head_data),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .wr_done   (pop),
    .rd_done   (rd_done)
  );

endmodule

// File: rtl/pwb_ctrl_chk.sv
// Port-level properties of the posted write buffer controller.
module pwb_ctrl_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_write,
  input logic          cpu_ready,
  input logic          wr_open,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);

  AST_READY_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);  // R2

  AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> $past(cpu_req));  // R2

  AST_CLOSED_NO_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_open |=> !(cpu_ready && cpu_write));  // R4

  AST_DRAIN_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> wr_open);  // R5

  AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));  // R9

  AST_MEM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);  // R9

endmodule

bind pwb_ctrl pwb_ctrl_chk #(.AW(AW), .DW(DW)) u_pwb_ctrl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_write (cpu_write),
  .cpu_ready (cpu_ready),
  .wr_open   (wr_open),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/test_pwb_ctrl.sv
module test_pwb_ctrl;

  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_write;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          wr_open;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwb_ctrl #(.DEPTH(2), .AW(AW), .DW(DW)) i_pwb_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .wr_open(wr_open),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;

  int  cyc = 0;
  int  errors = 0, checks = 0;
  wr_t exp_q[$];
  wr_t exp_e;
  logic [DW-1:0] arr [256];
  bit  hold_wr = 1'b0;
  int  wait_cnt = 0;
  bit  last_we = 1'b0;
  bit  arm_first = 1'b0;
  bit  found;
  int  first_ack_cyc = 0, rd_ack_cyc = 0, rd_ack_qlen = 0;
  int  ready_cyc = 0;
  bit  open_at_start, open_at_ready;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
    return 32'hC0DE_0000 | DW'(a);
  endfunction

  function automatic void chk(input bit ok, input string rq, input string what,
                              input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endfunction

  // Memory model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack  <= 1'b0;
      wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      chk(!mem_req, "R9", "request dropped after acknowledge", mem_req, 0);
      if (last_we) chk(wr_open, "R5", "wr_open after drain", wr_open, 1);
    end else if (mem_req && !(mem_we && hold_wr)) begin
      if (wait_cnt == LAT) begin
        wait_cnt = 0;
        mem_ack <= 1'b1;
        last_we = mem_we;
        if (mem_we) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6", "unexpected drain", mem_addr, 0);
          end else begin
            exp_e = exp_q.pop_front();
            chk(mem_addr == exp_e.a, "R6", "drain address", mem_addr, exp_e.a);
            chk(mem_wdata == exp_e.d, "R6", "drain data", mem_wdata, exp_e.d);
          end
          arr[mem_addr] = mem_wdata;
          if (arm_first) begin
            first_ack_cyc = cyc;
            arm_first = 1'b0;
          end
        end else begin
          mem_rdata <= arr[mem_addr];
          rd_ack_cyc  = cyc;
          rd_ack_qlen = exp_q.size();
          found = 1'b0;
          foreach (exp_q[k]) if (exp_q[k].a == mem_addr) found = 1'b1;
          chk(!found, "R8", "read issued past matching queued write", found, 0);
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_write = 1'b1; cpu_addr = a; cpu_wdata = d;
    open_at_start = wr_open;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpu_ready);
    exp_q.push_back('{a: a, d: d});
    ready_cyc     = cyc;
    open_at_ready = wr_open;
    cpu_req = 1'b0; cpu_write = 1'b0;
  endtask

  task automatic host_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_write = 1'b0; cpu_addr = a;
    do @(negedge clk); while (!cpu_ready);
    d         = cpu_rdata;
    ready_cyc = cyc;
    cpu_req   = 1'b0;
  endtask

  task automatic wait_drain();
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !mem_req && !mem_ack) break;
    end
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    logic [DW-1:0] rd;
    bit done;

    for (int i = 0; i < 256; i++) arr[i] = init_val(AW'(i));
    rst_n = 1'b0; cpu_req = 1'b0; cpu_write = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    chk(wr_open && !cpu_ready && !mem_req, "R1", "state in reset",
        {wr_open, cpu_ready, mem_req}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_open && !cpu_ready && !mem_req, "R1", "state after release",
        {wr_open, cpu_ready, mem_req}, 3'b100);

    // Posting with a running memory
    for (int i = 0; i < 4; i++) begin
      host_write(AW'(8'h50 + i), 32'h1111_0000 + i, lat);
      if (i == 0 || open_at_start) chk(lat == 1, "R2", "write acknowledge latency", lat, 1);
    end
    wait_drain();

    // Fill, stall and release (R3, R4, R5)
    hold_wr = 1'b1;
    host_write(8'h01, 32'hAAAA_0001, lat);
    chk(lat == 1, "R2", "write latency with memory held", lat, 1);
    chk(open_at_ready, "R3", "wr_open with one slot left", open_at_ready, 1);
    host_write(8'h02, 32'hAAAA_0002, lat);
    chk(!open_at_ready, "R3", "wr_open at filling acknowledge", open_at_ready, 0);
    done = 1'b0;
    fork
      begin
        int l3;
        host_write(8'h03, 32'hAAAA_0003, l3);
        done = 1'b1;
      end
    join_none
    repeat (6) @(negedge clk);
    chk(!done, "R4", "write acknowledged while full", done, 0);
    chk(!wr_open, "R4", "wr_open while full", wr_open, 0);
    arm_first = 1'b1;
    hold_wr = 1'b0;
    wait (done);
    chk(ready_cyc - first_ack_cyc == 2, "R4", "stalled write acknowledge delay",
        ready_cyc - first_ack_cyc, 2);
    wait_drain();

    // Non-matching read behind a full queue (R7, R10)
    hold_wr = 1'b1;
    host_write(8'h21, 32'hBBBB_0021, lat);
    host_write(8'h22, 32'hBBBB_0022, lat);
    done = 1'b0;
    fork
      begin
        logic [DW-1:0] r;
        host_read(8'h40, r);
        rd = r;
        done = 1'b1;
      end
    join_none
    repeat (4) @(negedge clk);
    chk(!wr_open, "R7", "read presented while writes closed", wr_open, 0);
    hold_wr = 1'b0;
    wait (done);
    chk(rd_ack_qlen == 1, "R7", "queued writes left when read served", rd_ack_qlen, 1);
    chk(rd == init_val(8'h40), "R10", "read data", rd, init_val(8'h40));
    chk(ready_cyc == rd_ack_cyc + 1, "R10", "read acknowledge cycle", ready_cyc, rd_ack_cyc + 1);
    wait_drain();

    // Matching read waits for its entry (R8)
    hold_wr = 1'b1;
    host_write(8'h30, 32'hCCCC_0030, lat);
    host_write(8'h10, 32'hCCCC_0010, lat);
    done = 1'b0;
    fork
      begin
        logic [DW-1:0] r;
        host_read(8'h10, r);
        rd = r;
        done = 1'b1;
      end
    join_none
    repeat (6) @(negedge clk);
    chk(!done, "R8", "matching read served early", done, 0);
    hold_wr = 1'b0;
    wait (done);
    chk(rd_ack_qlen == 0, "R8", "queued writes left when read served", rd_ack_qlen, 0);
    chk(rd == 32'hCCCC_0010, "R8", "read after write data", rd, 32'hCCCC_0010);
    wait_drain();

    // Write then read back, plus untouched reads
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'(8'h80 + 3 * i);
      d = 32'h5A00_0000 + 77 * i;
      host_write(a, d, lat);
      if (open_at_start) chk(lat == 1, "R2", "write latency in mix", lat, 1);
      host_read(a, rd);
      chk(rd == d, "R8", "read back", rd, d);
      host_read(AW'(8'hF0 + i), rd);
      chk(rd == init_val(AW'(8'hF0 + i)), "R10", "untouched read", rd, init_val(AW'(8'hF0 + i)));
    end
    wait_drain();
    chk(exp_q.size() == 0, "R6", "all posted writes drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule